// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block sequences instruction addresses for a small controller that fetches one 14-bit instruction word per cycle. It holds a 13-bit program counter, made of an 8-bit low byte and a 5-bit page part, and drives that value straight onto the program memory address bus. In each cycle the decoder supplies a control code for the instruction now being executed at `addr_o`. The block then either steps to the next word, steps over one word after a test that passed, loads a jump or call target, takes a return address back, or loads the low byte from the data bus. An interrupt request overrides the control code. It saves the address being abandoned and moves to the fixed service entry at 0004.

Return addresses sit in a private last-in first-out store that only calls, returns and interrupts reach. When the store is full, a new entry replaces the oldest one. When it is empty, a return gives back the value taken by the most recent successful return. Two sticky flags record these events. A separate page latch is written from the data bus. It supplies the upper address bits for jump, call and low-byte loads.

The controller has two states. BOOT lasts for the first cycle after reset is released. The counter holds 0000 during it and every request is ignored. The transition boot_done leads to RUN, which loops on itself (run_loop) until reset.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is low, `addr_o` is 0000, `stk_level_o` is 0 and both flags are 0. In the first clock edge after release (state BOOT), the counter stays at 0000 and `op_i`, `skip_i` and `irq_i` have no effect.
- R2: `op_i` = 3'b000 (and the unused codes 3'b101, 3'b110, 3'b111) with `skip_i` = 0 advances the address by one. The low byte rolls from FF to 00 with a carry into the page bits (00FF becomes 0100), and 1FFF wraps to 0000.
- R3: `op_i` = 3'b000 with `skip_i` = 1 advances the address by two, with the same page carry (00FE becomes 0100, 1FFE becomes 0000).
- R4: `op_i` = 3'b001 (jump) loads {latch bits 4:3, `target_i`[10:0]}.
- R5: `op_i` = 3'b010 (call) loads the same address as a jump and pushes the call's address plus one.
- R6: `op_i` = 3'b011 (return) loads the most recently pushed entry still held and removes it (LIFO order).
- R7: `op_i` = 3'b100 (low-byte write) loads {latch bits 4:0, `bus_wdata_i`[7:0]}.
- R8: `hi_wr_i` = 1 writes `bus_wdata_i` into the page latch at the clock edge. An operation in the same cycle uses the old latch value. Latch bits 7:5 never reach the address.
- R9: In RUN, `irq_i` = 1 overrides `op_i`: the current `addr_o` is pushed and the counter loads 0004.
- R10: `skip_i` has no effect with codes 3'b001 to 3'b100 or with an interrupt.
- R11: A push while 8 entries are held drops the oldest entry, keeps the level at 8 and sets `stk_ovf_o`, which stays set until reset.
- R12: A return with the store empty loads the value returned by the last successful return (0000 if none since reset), keeps the level at 0 and sets `stk_unf_o`, which stays set until reset.
- R13: `stk_level_o` equals the number of entries held, never above 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Control code for the instruction at `addr_o` |
| target_i | input | 11 | Jump/call target operand |
| skip_i | input | 1 | Skip request from a passed bit test |
| irq_i | input | 1 | Interrupt accepted this cycle |
| bus_wdata_i | input | 8 | Data bus write value |
| hi_wr_i | input | 1 | Write strobe for the page latch |
| addr_o | output | 13 | Program memory address |
| stk_level_o | output | 4 | Entries held in the return store |
| stk_ovf_o | output | 1 | Sticky push-on-full flag |
| stk_unf_o | output | 1 | Sticky pop-on-empty flag |

## Verification
The bench builds the block with its default parameters: a 13-bit address, an 8-bit low byte, an 11-bit target and an 8-deep store. With these values every one of the 8192 addresses can be stepped through in one sweep, including every page carry and the top-of-memory wrap. All 256 low-byte values and every latch value can be combined with loads. Because the store is only 8 deep, pushing past full and popping past empty are quick to reach. They are checked against an arithmetic model, as is a long pseudo-random mix of all operations.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    // control codes from the decoder
    localparam logic [2:0] OPC_NEXT = 3'd0;
    localparam logic [2:0] OPC_JUMP = 3'd1;
    localparam logic [2:0] OPC_CALL = 3'd2;
    localparam logic [2:0] OPC_RET  = 3'd3;
    localparam logic [2:0] OPC_PCLW = 3'd4;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1
    } seq_state_e;

    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_INC  = 3'd1,
        ACT_SKIP = 3'd2,
        ACT_JUMP = 3'd3,
        ACT_CALL = 3'd4,
        ACT_RET  = 3'd5,
        ACT_PCL  = 3'd6,
        ACT_IRQ  = 3'd7
    } seq_act_e;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
    import pcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] op_i,
    input  logic       skip_i,
    input  logic       irq_i,
    output seq_act_e   act_o,
    output logic       run_o
);

    seq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // transitions: boot_done (BOOT -> RUN), run_loop (RUN -> RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    // outputs: action for this cycle
    always_comb begin
        act_o = ACT_HOLD;
        run_o = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                act_o = ACT_HOLD;
                run_o = 1'b0;
            end
            ST_RUN: begin
                run_o = 1'b1;
                if (irq_i) begin
                    act_o = ACT_IRQ;
                end else begin
                    case (op_i)
                        OPC_JUMP: act_o = ACT_JUMP;
                        OPC_CALL: act_o = ACT_CALL;
                        OPC_RET:  act_o = ACT_RET;
                        OPC_PCLW: act_o = ACT_PCL;
                        default:  act_o = skip_i ? ACT_SKIP : ACT_INC;
                    endcase
                end
            end
            default: begin
                act_o = ACT_HOLD;
                run_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int LO_W    = 8,
    parameter int TGT_W   = 11,
    parameter int IRQ_VEC = 4
) (
    input  seq_act_e             act_i,
    input  logic [ADDR_W-1:0]    pc_i,
    input  logic [ADDR_W-LO_W-1:0] latch_i,
    input  logic [TGT_W-1:0]     target_i,
    input  logic [LO_W-1:0]      bus_wdata_i,
    input  logic [ADDR_W-1:0]    pop_data_i,
    output logic [ADDR_W-1:0]    pc_d_o,
    output logic                 push_o,
    output logic [ADDR_W-1:0]    push_data_o,
    output logic                 pop_o
);

    localparam int HI_W  = ADDR_W - LO_W;
    localparam int TOP_W = ADDR_W - TGT_W;
    localparam int TOP_L = TGT_W - LO_W;

    logic [LO_W-1:0]   lo;
    logic [HI_W-1:0]   hi;
    logic [LO_W:0]     lo_sum1, lo_sum2;
    logic [HI_W-1:0]   hi_sum1, hi_sum2;
    logic [ADDR_W-1:0] inc1, inc2, jmp, pcl;

    // page-carry increment: low byte first, carry into page part
    always_comb begin
        lo      = pc_i[LO_W-1:0];
        hi      = pc_i[ADDR_W-1:LO_W];
        lo_sum1 = {1'b0, lo} + (LO_W+1)'(1);
        lo_sum2 = {1'b0, lo} + (LO_W+1)'(2);
        hi_sum1 = hi + HI_W'(lo_sum1[LO_W]);
        hi_sum2 = hi + HI_W'(lo_sum2[LO_W]);
        inc1    = {hi_sum1, lo_sum1[LO_W-1:0]};
        inc2    = {hi_sum2, lo_sum2[LO_W-1:0]};
        jmp     = {latch_i[TOP_L +: TOP_W], target_i};
        pcl     = {latch_i, bus_wdata_i};
    end

    always_comb begin
        pc_d_o      = pc_i;
        push_o      = 1'b0;
        push_data_o = inc1;
        pop_o       = 1'b0;
        unique case (act_i)
            ACT_HOLD: pc_d_o = pc_i;
            ACT_INC:  pc_d_o = inc1;
            ACT_SKIP: pc_d_o = inc2;
            ACT_JUMP: pc_d_o = jmp;
            ACT_CALL: begin
                pc_d_o      = jmp;
                push_o      = 1'b1;
                push_data_o = inc1;
            end
            ACT_RET: begin
                pc_d_o = pop_data_i;
                pop_o  = 1'b1;
            end
            ACT_PCL:  pc_d_o = pcl;
            ACT_IRQ: begin
                pc_d_o      = ADDR_W'(IRQ_VEC);
                push_o      = 1'b1;
                push_data_o = pc_i;
            end
            default:  pc_d_o = pc_i;
        endcase
    end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_i,
    input  logic [W-1:0]                push_data_i,
    input  logic                        pop_i,
    output logic [W-1:0]                pop_data_o,
    output logic [$clog2(DEPTH+1)-1:0]  level_o,
    output logic                        ovf_o,
    output logic                        unf_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, top_idx, wr_next;
    logic [LVL_W-1:0] level_q;
    logic [W-1:0]     last_q;
    logic             empty, full;

    assign empty   = (level_q == '0);
    assign full    = (level_q == LVL_W'(DEPTH));
    assign top_idx = (wr_ptr_q == '0) ? PTR_W'(DEPTH-1) : wr_ptr_q - 1'b1;
    assign wr_next = (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;

    // one storage entry per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_i && wr_ptr_q == PTR_W'(g)) mem[g] <= push_data_i;
        end
    end

    assign pop_data_o = empty ? last_q : mem[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            level_q  <= '0;
            last_q   <= '0;
            ovf_o    <= 1'b0;
            unf_o    <= 1'b0;
        end else if (push_i) begin
            wr_ptr_q <= wr_next;
            if (full) ovf_o   <= 1'b1;
            else      level_q <= level_q + 1'b1;
        end else if (pop_i) begin
            if (empty) begin
                unf_o <= 1'b1;
            end else begin
                last_q   <= mem[top_idx];
                wr_ptr_q <= top_idx;
                level_q  <= level_q - 1'b1;
            end
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int LO_W      = 8,
    parameter int TGT_W     = 11,
    parameter int STK_DEPTH = 8,
    parameter int IRQ_VEC   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [2:0]                      op_i,
    input  logic [TGT_W-1:0]                target_i,
    input  logic                            skip_i,
    input  logic                            irq_i,
    input  logic [LO_W-1:0]                 bus_wdata_i,
    input  logic                            hi_wr_i,
    output logic [ADDR_W-1:0]               addr_o,
    output logic [$clog2(STK_DEPTH+1)-1:0]  stk_level_o,
    output logic                            stk_ovf_o,
    output logic                            stk_unf_o
);

    localparam int HI_W = ADDR_W - LO_W;

    seq_act_e          act;
    logic              run_w;
    logic [ADDR_W-1:0] pc_q, pc_d;
    logic [HI_W-1:0]   latch_q;
    logic              push, pop;
    logic [ADDR_W-1:0] push_data, pop_data;

    pcseq_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op_i),
        .skip_i (skip_i),
        .irq_i  (irq_i),
        .act_o  (act),
        .run_o  (run_w)
    );

    pcseq_next #(
        .ADDR_W  (ADDR_W),
        .LO_W    (LO_W),
        .TGT_W   (TGT_W),
        .IRQ_VEC (IRQ_VEC)
    ) u_next (
        .act_i       (act),
        .pc_i        (pc_q),
        .latch_i     (latch_q),
        .target_i    (target_i),
        .bus_wdata_i (bus_wdata_i),
        .pop_data_i  (pop_data),
        .pc_d_o      (pc_d),
        .push_o      (push),
        .push_data_o (push_data),
        .pop_o       (pop)
    );

    pcseq_stack #(
        .DEPTH (STK_DEPTH),
        .W     (ADDR_W)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (push_data),
        .pop_i       (pop),
        .pop_data_o  (pop_data),
        .level_o     (stk_level_o),
        .ovf_o       (stk_ovf_o),
        .unf_o       (stk_unf_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // page latch keeps only the bits that reach the address
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (hi_wr_i) latch_q <= bus_wdata_i[HI_W-1:0];
    end

    assign addr_o = pc_q;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
    parameter int ADDR_W    = 13,
    parameter int STK_DEPTH = 8,
    parameter int IRQ_VEC   = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [2:0]                     op_i,
    input logic                           skip_i,
    input logic                           irq_i,
    input logic                           run_i,
    input logic [ADDR_W-1:0]              addr_o,
    input logic [$clog2(STK_DEPTH+1)-1:0] stk_level_o,
    input logic                           stk_ovf_o,
    input logic                           stk_unf_o
);

    logic [ADDR_W-1:0] plus1, plus2;
    logic              plain_next;
    assign plus1 = addr_o + 1'b1;
    assign plus2 = addr_o + 2'd2;
    assign plain_next = run_i && !irq_i &&
                        (op_i == 3'd0 || op_i == 3'd5 || op_i == 3'd6 || op_i == 3'd7);

    a_r1_boot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> addr_o == '0);

    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        plain_next && !skip_i |=> addr_o == $past(plus1));

    a_r3_step_two: assert property (@(posedge clk) disable iff (!rst_n)
        plain_next && skip_i |=> addr_o == $past(plus2));

    a_r9_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && irq_i |=> addr_o == ADDR_W'(IRQ_VEC));

    a_r6_ret_level: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !irq_i && op_i == 3'd3 && stk_level_o != '0
        |=> stk_level_o == $past(stk_level_o) - 1'b1);

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf_o |=> stk_ovf_o);

    a_r12_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_unf_o |=> stk_unf_o);

    a_r13_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stk_level_o <= ($clog2(STK_DEPTH+1))'(STK_DEPTH));

endmodule

bind pc_sequencer pcseq_chk #(
    .ADDR_W    (ADDR_W),
    .STK_DEPTH (STK_DEPTH),
    .IRQ_VEC   (IRQ_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .skip_i      (skip_i),
    .irq_i       (irq_i),
    .run_i       (run_w),
    .addr_o      (addr_o),
    .stk_level_o (stk_level_o),
    .stk_ovf_o   (stk_ovf_o),
    .stk_unf_o   (stk_unf_o)
);

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;

    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_i;
    logic [10:0] target_i;
    logic        skip_i, irq_i, hi_wr_i;
    logic [7:0]  bus_wdata_i;
    logic [12:0] addr_o;
    logic [3:0]  stk_level_o;
    logic        stk_ovf_o, stk_unf_o;

    always #(CLK_T/2) clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op_i),
        .target_i    (target_i),
        .skip_i      (skip_i),
        .irq_i       (irq_i),
        .bus_wdata_i (bus_wdata_i),
        .hi_wr_i     (hi_wr_i),
        .addr_o      (addr_o),
        .stk_level_o (stk_level_o),
        .stk_ovf_o   (stk_ovf_o),
        .stk_unf_o   (stk_unf_o)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model
    int m_pc, m_latch, m_last;
    int m_q[$];
    bit m_ovf, m_unf;
    int unsigned seed = 32'h1357_9bdf;

    task automatic check(string req, string what, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic m_push(int v);
        if (m_q.size() == 8) begin
            void'(m_q.pop_front());
            m_ovf = 1;
        end
        m_q.push_back(v);
    endtask

    task automatic m_pop(output int v);
        if (m_q.size() == 0) begin
            m_unf = 1;
            v = m_last;
        end else begin
            m_last = m_q.pop_back();
            v = m_last;
        end
    endtask

    task automatic step(input int op, input int tgt, input bit sk, input bit ir,
                        input int bus, input bit hw, input string req);
        int nv;
        @(negedge clk);
        op_i = 3'(op); target_i = 11'(tgt); skip_i = sk; irq_i = ir;
        bus_wdata_i = 8'(bus); hi_wr_i = hw;
        if (ir) begin
            m_push(m_pc);
            m_pc = 4;
        end else begin
            case (op)
                1: m_pc = (((m_latch >> 3) & 3) << 11) | (tgt & 2047);
                2: begin
                    m_push((m_pc + 1) % 8192);
                    m_pc = (((m_latch >> 3) & 3) << 11) | (tgt & 2047);
                end
                3: begin
                    m_pop(nv);
                    m_pc = nv;
                end
                4: m_pc = ((m_latch & 31) << 8) | (bus & 255);
                default: m_pc = (m_pc + (sk ? 2 : 1)) % 8192;
            endcase
        end
        if (hw) m_latch = bus & 255;
        @(posedge clk);
        #1;
        check(req, "addr", int'(addr_o), m_pc);
        check("R13", "stack status", int'({stk_level_o, stk_ovf_o, stk_unf_o}),
              (m_q.size() << 2) | (int'(m_ovf) << 1) | int'(m_unf));
    endtask

    task automatic next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; op_i = 0; target_i = 0; skip_i = 0; irq_i = 0;
        bus_wdata_i = 0; hi_wr_i = 0;
        m_pc = 0; m_latch = 0; m_last = 0; m_ovf = 0; m_unf = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "reset addr", int'(addr_o), 0);
        check("R1", "reset status", int'({stk_level_o, stk_ovf_o, stk_unf_o}), 0);

        // R1: boot cycle ignores requests
        @(negedge clk);
        rst_n = 1; op_i = 3'd2; target_i = 11'h155; irq_i = 1; skip_i = 1;
        @(posedge clk);
        #1;
        check("R1", "boot addr", int'(addr_o), 0);
        check("R1", "boot level", int'(stk_level_o), 0);

        // R2: full address sweep with page carries and top wrap
        for (int i = 0; i < 8192; i++) begin
            int op;
            op = (i % 4 == 0) ? 5 + (i / 4) % 3 : 0;
            step(op, 0, 0, 0, 0, 0, "R2");
        end
        check("R2", "wrap to zero", int'(addr_o), 0);

        // R3: skip sweep across several pages
        for (int i = 0; i < 600; i++) step(0, 0, 1, 0, 0, 0, "R3");
        // R3: skip over the top of memory; latch 0x18 then jump to 0x7FE
        step(0, 0, 0, 0, 8'h18, 1, "R8");
        step(1, 11'h7fe, 0, 0, 0, 0, "R4");
        check("R4", "top page jump", int'(addr_o), 13'h1ffe);
        step(0, 0, 1, 0, 0, 0, "R3");
        check("R3", "skip wrap", int'(addr_o), 0);

        // R4 / R8: jumps across latch values, latch written in same cycle
        for (int l = 0; l < 256; l += 7) begin
            step(0, 0, 0, 0, l, 1, "R8");
            for (int t = 0; t < 4; t++) begin
                step(1, (l * 13 + t * 517) % 2048, t % 2, 0, (l + 96) % 256, t == 3, "R4");
            end
        end

        // R7 / R10: low-byte writes for every byte value
        for (int b = 0; b < 256; b++) begin
            if (b % 32 == 0) step(0, 0, 0, 0, 255 - b, 1, "R8");
            step(4, 0, b % 2, 0, b, 0, "R7");
        end

        // R5 / R6: nested calls to depth 1..8 then returns
        for (int d = 1; d <= 8; d++) begin
            for (int k = 0; k < d; k++) step(2, 100 * d + k * 9, k % 2, 0, 0, 0, "R5");
            for (int k = 0; k < d; k++) step(3, 0, k % 2, 0, 0, 0, "R6");
        end
        check("R11", "no overflow yet", int'(stk_ovf_o), 0);

        // R12: return on empty store
        step(3, 0, 0, 0, 0, 0, "R12");
        step(3, 0, 1, 0, 0, 0, "R12");
        check("R12", "underflow flag", int'(stk_unf_o), 1);

        // R11: eleven calls then eleven returns
        for (int k = 0; k < 11; k++) step(2, 40 + k * 3, 0, 0, 0, 0, "R11");
        check("R11", "level full", int'(stk_level_o), 8);
        for (int k = 0; k < 11; k++) step(3, 0, 0, 0, 0, 0, "R11");
        check("R11", "overflow flag", int'(stk_ovf_o), 1);

        // R9: interrupts over various codes, then return
        for (int k = 0; k < 8; k++) begin
            step(1, 300 + k, 0, 0, 0, 0, "R4");
            step(k % 5, 77, 1, 1, k, 0, "R9");
            step(3, 0, 0, 0, 0, 0, "R9");
        end

        // mixed pseudo-random operations
        for (int i = 0; i < 3000; i++) begin
            next_rand();
            step(int'(seed[18:16]), int'(seed[30:20]), seed[5], seed[9:6] == 0,
                 int'(seed[15:8]), seed[3:1] == 0, "mixed");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule